// File: doc/BRIEF.md
# Host-to-Card Stream Packet Checker

This block is the sink at the end of a host-to-card streaming path. It accepts 64-byte beats under a valid/ready handshake. Each beat carries odd per-byte parity. The final beat of a packet is marked and states how many of its trailing bytes are unused. A separate flag marks a beat that carries no data at all. Every beat also brings an error flag and three packet descriptors: a queue number, a port number and a 32-bit metadata word.

For each packet the block does four things:
- It totals the valid bytes.
- It checks parity on those bytes only.
- It collects any error flag seen on the packet's beats.
- It holds the descriptors taken from the first beat, and notes whether a later beat showed different ones.

When the final beat arrives, the block presents a one-cycle status record on the following clock. It drops ready for that one cycle, so no beat can transfer while the record is out.

Top module: `h2c_pkt_checker`

## Requirements
- R1: A beat transfers only on a clock where `in_valid` and `in_ready` are both high. Beats offered while valid is low are ignored, including every sideband on them.
- R2: A transferred beat that is neither the final beat nor a zero-byte beat adds 64 to the packet byte count.
- R3: A final beat without the zero-byte flag adds 64 minus `in_mty`, where `in_mty` = 0 means 64 bytes.
- R4: A beat with `in_zero` high adds 0 bytes. None of its bytes is parity-checked.
- R5: Parity is odd. Bit i of `in_par` covers `in_data[8i+7:8i]`. A valid byte whose eight bits plus its parity bit hold an even number of ones sets `st_par_err`.
- R6: On a final beat, bytes at index 64 minus `in_mty` and above are not parity-checked.
- R7: `in_err` high on any transferred beat of a packet sets `st_err` in that packet's record.
- R8: `st_qid`, `st_port` and `st_meta` report the values seen on the first transferred beat of the packet.
- R9: `st_mismatch` is set when any later beat of the same packet shows a queue, port or metadata value different from the first beat's.
- R10: `st_valid` is high for exactly one cycle, the cycle after the final beat transfers. `in_ready` is low in that cycle and high in every other cycle outside reset.
- R11: Synchronous active-high reset discards any partial packet, clears `st_valid` and leaves `in_ready` high.
- R12: A final beat that also has `in_zero` set adds 0 bytes, whatever the value of `in_mty`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | 512 | Beat data |
| in_par | input | 64 | Odd parity, one bit per data byte |
| in_mty | input | 6 | Unused trailing bytes on the final beat |
| in_zero | input | 1 | Beat carries no data |
| in_err | input | 1 | Upstream error on this beat |
| in_qid | input | 11 | Queue number |
| in_port | input | 3 | Port number |
| in_meta | input | 32 | Packet metadata |
| in_last | input | 1 | Final beat of the packet |
| in_valid | input | 1 | Beat offered |
| in_ready | output | 1 | Beat accepted when high with valid |
| st_valid | output | 1 | Status record present, one cycle |
| st_bytes | output | 16 | Valid byte total of the packet |
| st_par_err | output | 1 | A valid byte failed odd parity |
| st_err | output | 1 | An error flag was seen on the packet |
| st_mismatch | output | 1 | Descriptors changed within the packet |
| st_qid | output | 11 | Queue number of the packet |
| st_port | output | 3 | Port number of the packet |
| st_meta | output | 32 | Metadata of the packet |

## Verification
The hardest case to reach is a parity fault that must be ignored. The broken parity bit has to sit on a byte that is invalid only because of where it is: just past the boundary set by `in_mty` on a final beat, or anywhere inside a zero-byte beat. The stimulus flips single parity bits at exact byte indices on either side of that boundary. It also flips them inside zero-byte beats, including a final beat that is zero-byte while `in_mty` is nonzero. Reset in the middle of a packet, and idle cycles whose sidebands carry misleading values, are driven so that any stale or spurious state would show up in the following record.

// File: rtl/h2c_pkt_checker.sv
module h2c_pkt_checker #(
  parameter int DATA_W = 512,
  parameter int QID_W  = 11,
  parameter int PORT_W = 3,
  parameter int META_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [DATA_W-1:0]           in_data,
  input  logic [DATA_W/8-1:0]         in_par,
  input  logic [$clog2(DATA_W/8)-1:0] in_mty,
  input  logic                        in_zero,
  input  logic                        in_err,
  input  logic [QID_W-1:0]            in_qid,
  input  logic [PORT_W-1:0]           in_port,
  input  logic [META_W-1:0]           in_meta,
  input  logic                        in_last,
  input  logic                        in_valid,
  output logic                        in_ready,
  output logic                        st_valid,
  output logic [CNT_W-1:0]            st_bytes,
  output logic                        st_par_err,
  output logic                        st_err,
  output logic                        st_mismatch,
  output logic [QID_W-1:0]            st_qid,
  output logic [PORT_W-1:0]           st_port,
  output logic [META_W-1:0]           st_meta
);
  localparam int NB    = DATA_W / 8;
  localparam int MTY_W = $clog2(NB);

  logic              in_pkt;
  logic [CNT_W-1:0]  acc_bytes;
  logic              acc_perr, acc_err, acc_mis;
  logic [QID_W-1:0]  cap_qid;
  logic [PORT_W-1:0] cap_port;
  logic [META_W-1:0] cap_meta;

  logic [MTY_W:0]    n_valid;
  logic [NB-1:0]     byte_bad;
  logic [CNT_W-1:0]  tot_bytes;
  logic              beat_mis;
  logic              fire;

  assign in_ready  = ~st_valid;
  assign fire      = in_valid & in_ready;
  assign n_valid   = in_zero ? '0 :
                     in_last ? ((MTY_W+1)'(NB) - {1'b0, in_mty}) : (MTY_W+1)'(NB);
  assign tot_bytes = acc_bytes + CNT_W'(n_valid);
  assign beat_mis  = in_pkt && ((in_qid != cap_qid) || (in_port != cap_port) ||
                                (in_meta != cap_meta));

  for (genvar i = 0; i < NB; i++) begin : g_byte
    assign byte_bad[i] = ((MTY_W+1)'(i) < n_valid) &&
                         ~(^{in_data[8*i +: 8], in_par[i]});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_pkt      <= 1'b0;
      acc_bytes   <= '0;
      acc_perr    <= 1'b0;
      acc_err     <= 1'b0;
      acc_mis     <= 1'b0;
      cap_qid     <= '0;
      cap_port    <= '0;
      cap_meta    <= '0;
      st_valid    <= 1'b0;
      st_bytes    <= '0;
      st_par_err  <= 1'b0;
      st_err      <= 1'b0;
      st_mismatch <= 1'b0;
      st_qid      <= '0;
      st_port     <= '0;
      st_meta     <= '0;
    end else begin
      st_valid <= 1'b0;
      if (fire) begin
        if (in_last) begin
          st_valid    <= 1'b1;
          st_bytes    <= tot_bytes;
          st_par_err  <= acc_perr | (|byte_bad);
          st_err      <= acc_err | in_err;
          st_mismatch <= acc_mis | beat_mis;
          st_qid      <= in_pkt ? cap_qid  : in_qid;
          st_port     <= in_pkt ? cap_port : in_port;
          st_meta     <= in_pkt ? cap_meta : in_meta;
          in_pkt      <= 1'b0;
          acc_bytes   <= '0;
          acc_perr    <= 1'b0;
          acc_err     <= 1'b0;
          acc_mis     <= 1'b0;
        end else begin
          in_pkt    <= 1'b1;
          acc_bytes <= tot_bytes;
          acc_perr  <= acc_perr | (|byte_bad);
          acc_err   <= acc_err | in_err;
          acc_mis   <= acc_mis | beat_mis;
          if (!in_pkt) begin
            cap_qid  <= in_qid;
            cap_port <= in_port;
            cap_meta <= in_meta;
          end
        end
      end
    end
  end
endmodule

// File: rtl/h2c_pkt_checker_sva.sv
module h2c_pkt_checker_sva (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_last,
  input logic in_err,
  input logic in_ready,
  input logic st_valid,
  input logic st_err
);
  logic fire_last;
  assign fire_last = in_valid && in_ready && in_last;

  AST_READY_LOW_ON_STATUS: assert property (@(posedge clk) disable iff (rst)
    st_valid |-> !in_ready); // R10
  AST_STATUS_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    st_valid |=> !st_valid); // R10
  AST_STATUS_FOLLOWS_LAST: assert property (@(posedge clk) disable iff (rst)
    fire_last |=> st_valid); // R1
  AST_STATUS_NEEDS_LAST: assert property (@(posedge clk) disable iff (rst)
    (st_valid && !$past(rst)) |-> $past(fire_last)); // R1
  AST_ERR_ON_LAST_KEPT: assert property (@(posedge clk) disable iff (rst)
    (fire_last && in_err) |=> st_err); // R7
  AST_RESET_IDLE: assert property (@(posedge clk)
    $past(rst) |-> (!st_valid && in_ready)); // R11
endmodule

bind h2c_pkt_checker h2c_pkt_checker_sva u_sva (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_last(in_last), .in_err(in_err),
  .in_ready(in_ready), .st_valid(st_valid), .st_err(st_err)
);

// File: tb/h2c_pkt_checker_tb_top.sv
`timescale 1ns/1ps
module h2c_pkt_checker_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [511:0] in_data = '0;
  logic [63:0]  in_par = '0;
  logic [5:0]   in_mty = '0;
  logic         in_zero = 1'b0, in_err = 1'b0, in_last = 1'b0, in_valid = 1'b0;
  logic [10:0]  in_qid = '0;
  logic [2:0]   in_port = '0;
  logic [31:0]  in_meta = '0;
  logic         in_ready, st_valid, st_par_err, st_err, st_mismatch;
  logic [15:0]  st_bytes;
  logic [10:0]  st_qid;
  logic [2:0]   st_port;
  logic [31:0]  st_meta;

  int checks = 0;
  int errors = 0;

  typedef struct {
    int          bytes;
    bit          perr, err, mis;
    logic [10:0] qid;
    logic [2:0]  port;
    logic [31:0] meta;
    string       tag;
  } rec_t;
  rec_t exp_q[$];

  always #2.5 clk = ~clk;

  h2c_pkt_checker dut_i (
    .clk(clk), .rst(rst), .in_data(in_data), .in_par(in_par), .in_mty(in_mty),
    .in_zero(in_zero), .in_err(in_err), .in_qid(in_qid), .in_port(in_port),
    .in_meta(in_meta), .in_last(in_last), .in_valid(in_valid), .in_ready(in_ready),
    .st_valid(st_valid), .st_bytes(st_bytes), .st_par_err(st_par_err),
    .st_err(st_err), .st_mismatch(st_mismatch), .st_qid(st_qid),
    .st_port(st_port), .st_meta(st_meta)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Monitor: pop and compare every status record
  always @(negedge clk) begin
    if (!rst && st_valid) begin
      check(in_ready == 1'b0, "R10", "ready during status", in_ready, 0);
      if (exp_q.size() == 0) begin
        check(1'b0, "R1", "unexpected status record", 1, 0);
      end else begin
        rec_t e;
        e = exp_q.pop_front();
        check(st_bytes == e.bytes[15:0], e.tag, "bytes", st_bytes, e.bytes);
        check(st_par_err == e.perr, e.tag, "par_err", st_par_err, e.perr);
        check(st_err == e.err, e.tag, "err", st_err, e.err);
        check(st_mismatch == e.mis, e.tag, "mismatch", st_mismatch, e.mis);
        check({st_qid, st_port, st_meta} == {e.qid, e.port, e.meta}, e.tag,
              "descriptors", {st_qid, st_port, st_meta}, {e.qid, e.port, e.meta});
      end
    end else if (!rst) begin
      check(in_ready == 1'b1, "R10", "ready when idle", in_ready, 1);
    end
  end

  task automatic drive_beat(input logic [511:0] d, input logic [63:0] p,
                            input int mty, input bit zero, input bit err, input bit last,
                            input logic [10:0] q, input logic [2:0] pt,
                            input logic [31:0] m, input int gap);
    for (int g = 0; g < gap; g++) begin
      in_valid = 1'b0; in_last = 1'b1; in_err = 1'b1; in_zero = 1'b0;
      in_qid = ~q; in_par = ~p;
      @(negedge clk);
    end
    in_data = d; in_par = p; in_mty = mty[5:0]; in_zero = zero; in_err = err;
    in_last = last; in_qid = q; in_port = pt; in_meta = m; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; in_err = 1'b0;
  endtask

  // Driver: computes the expected record from the requirements, then drives beats
  task automatic send_pkt(input string tag, input int nb, input int mty,
                          input int zero_mask, input int bad_beat, input int bad_idx,
                          input int err_beat, input int mis_beat, input int gap,
                          input logic [10:0] q, input logic [2:0] pt,
                          input logic [31:0] m);
    rec_t e;
    e.bytes = 0; e.perr = 0; e.err = 0; e.mis = (mis_beat > 0 && mis_beat < nb);
    e.qid = q; e.port = pt; e.meta = m; e.tag = tag;
    for (int b = 0; b < nb; b++) begin
      bit z = zero_mask[b];
      bit l = (b == nb - 1);
      int nv = z ? 0 : (l ? (mty == 0 ? 64 : 64 - mty) : 64);
      e.bytes += nv;
      if (b == bad_beat && bad_idx < nv) e.perr = 1;
      if (b == err_beat) e.err = 1;
    end
    exp_q.push_back(e);
    for (int b = 0; b < nb; b++) begin
      logic [511:0] d;
      logic [63:0]  p;
      for (int w = 0; w < 16; w++) d[32*w +: 32] = $urandom;
      for (int i = 0; i < 64; i++) p[i] = ~(^d[8*i +: 8]);
      if (b == bad_beat) p[bad_idx] = ~p[bad_idx];
      drive_beat(d, p, mty, zero_mask[b], b == err_beat, b == nb - 1,
                 (b == mis_beat) ? (q ^ 11'h1) : q, pt, m, gap);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(st_valid == 1'b0, "R11", "st_valid in reset", st_valid, 0);
    check(in_ready == 1'b1, "R11", "ready in reset", in_ready, 1);
    rst = 1'b0;
    @(negedge clk);

    send_pkt("R3",  1, 0,  0, -1, 0, -1, -1, 0, 11'h123, 3'd1, 32'hA0A0_0001);
    send_pkt("R2",  3, 10, 0, -1, 0, -1, -1, 0, 11'h7FF, 3'd7, 32'hDEAD_BEEF);
    send_pkt("R3",  1, 63, 0, -1, 0, -1, -1, 0, 11'h001, 3'd2, 32'h0000_0003);
    send_pkt("R4",  3, 0,  2,  1, 5, -1, -1, 0, 11'h055, 3'd3, 32'h1111_2222);
    send_pkt("R12", 2, 5,  2,  1, 0, -1, -1, 0, 11'h0AA, 3'd4, 32'h3333_4444);
    send_pkt("R5",  2, 0,  0,  0, 17, -1, -1, 0, 11'h200, 3'd5, 32'h5555_6666);
    send_pkt("R5",  1, 0,  0,  0, 63, -1, -1, 0, 11'h201, 3'd5, 32'h0);
    send_pkt("R5",  2, 0,  0,  1, 0, -1, -1, 0, 11'h202, 3'd6, 32'h1);
    send_pkt("R6",  2, 4,  0,  1, 60, -1, -1, 0, 11'h300, 3'd0, 32'h7);
    send_pkt("R6",  2, 4,  0,  1, 59, -1, -1, 0, 11'h301, 3'd0, 32'h8);
    send_pkt("R7",  3, 0,  0, -1, 0,  1, -1, 0, 11'h400, 3'd1, 32'h9);
    send_pkt("R7",  1, 0,  1, -1, 0,  0, -1, 0, 11'h401, 3'd1, 32'hA);
    send_pkt("R9",  3, 0,  0, -1, 0, -1,  2, 0, 11'h500, 3'd2, 32'hCAFE_F00D);
    send_pkt("R8",  2, 1,  0, -1, 0, -1, -1, 0, 11'h3C3, 3'd6, 32'h8765_4321);
    send_pkt("R1",  3, 8,  0, -1, 0, -1, -1, 2, 11'h111, 3'd3, 32'h2468_ACE0);

    // R11: partial packet discarded by reset
    drive_beat('1, '0, 0, 1'b0, 1'b1, 1'b0, 11'h666, 3'd7, 32'hFFFF_0000, 0);
    drive_beat('1, '1, 0, 1'b0, 1'b0, 1'b0, 11'h667, 3'd7, 32'hFFFF_0000, 0);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(st_valid == 1'b0, "R11", "st_valid after mid-packet reset", st_valid, 0);
    check(in_ready == 1'b1, "R11", "ready after mid-packet reset", in_ready, 1);
    rst = 1'b0;
    @(negedge clk);
    send_pkt("R11", 1, 32, 0, -1, 0, -1, -1, 0, 11'h010, 3'd0, 32'h1234_5678);

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R10", "records outstanding", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule